// File: doc/BRIEF.md
# Two-Cell Multilevel Inverter Gate Encoder

This block turns a signed target output level for a two-cell cascaded multilevel inverter into gate signals for every MOSFET in both cells. Each cell is an H-bridge leg pair with two added bidirectional switches, fed from two transformer windings of weight 1 and 2 (fine cell) or 7 and 14 (coarse cell). Together the cells reach 49 evenly spaced levels, from -24 to +24. Each bidirectional switch is built from two MOSFETs in anti-series. Device `a` carries current when the shared transformer primary is positive, and device `b` when it is negative.

The requested level is clamped, split into a coarse share and a fine share, and each share is mapped to one of seven switch patterns. The pattern is then mirrored when the primary is negative, so that the output level keeps its sign. A change in the set of conducting switches does not jump straight to the new pattern. The block first holds a timed intermediate state in which only the device matching the primary polarity is gated, with the other path left to its body diode. After that it applies both devices. A new request that arrives during this dwell waits until the dwell has ended. Upstream control is expected to align requests with the primary zero-voltage interval.

Top module: `ml_gate_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `gate_a` and `gate_b` are all zero after that edge.
- R2: Switch bit k-1 of a cell means switch Sk, for k = 1 to 6. Cell codes map to conducting switches as follows: 0 -> S2,S4; +1 -> S1,S6; -1 -> S3,S5; +2 -> S4,S5; -2 -> S2,S6; +3 -> S1,S4; -3 -> S2,S3.
- R3: A clamped level L is split as L = 7*c + f, with c and f each in -3..+3. The fine share f drives gate bits 5:0 and the coarse share c drives gate bits 11:6.
- R4: When `pri_pos` is 1, each cell uses its own share as its code. When `pri_pos` is 0, each cell uses the negated share.
- R5: In the steady state, `gate_a` and `gate_b` both equal the conducting-switch mask.
- R6: When the wanted mask differs from the applied mask and no dwell is running, the next edge starts a dwell. For exactly DWELL_CYC cycles, the new mask appears only on `gate_a` (when `pri_pos` is 1) or only on `gate_b` (when it is 0). The other bus is zero. The steady state follows.
- R7: A request that changes during a dwell is not acted on until the dwell completes. It then starts its own dwell on the edge after the steady state of the earlier request appears.
- R8: A change of inputs that leaves the conducting mask unchanged, such as a polarity reversal at level 0, starts no dwell and leaves the gates unchanged.
- R9: Targets above +24 are treated as +24, and targets below -24 are treated as -24.
- R10: Whenever any gate is on, each cell's conducting set satisfies S2 = NOR(S1,S5) and S4 = NOR(S3,S6). S5 is never on together with S1 or S2, and S6 is never on together with S3 or S4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lvl_target | input | 6 | Requested output level, two's complement |
| pri_pos | input | 1 | Primary polarity: 1 positive, 0 negative |
| gate_a | output | 12 | Positive-path MOSFET gates, cell 1 in bits 5:0, cell 2 in bits 11:6 |
| gate_b | output | 12 | Negative-path MOSFET gates, same layout |

## Verification
A new level request and the end of a running dwell can land in the same cycle. The bench provokes this by changing the target two cycles into a dwell. It then checks that the earlier mask still finishes its full intermediate window and reaches its steady state. Only after that should the later mask open its own dwell, one cycle later. A polarity reversal at a non-zero level is driven to show that a mirrored pattern passes through a dwell. The same reversal at level 0 is driven to show that no dwell is started.

// File: rtl/ml_enc_pkg.sv
// Shared constants, types and the per-cell switch pattern table for the
// multilevel gate encoder. Assumes a fixed seven-level cell (codes -3..+3).
package ml_enc_pkg;
    localparam int CELL_MAX  = 3;                      // largest cell code magnitude
    localparam int CELL_SPAN = 2 * CELL_MAX + 1;       // coarse cell weight
    localparam int N_CELLS   = 2;
    localparam int CELL_SW   = 6;                      // switches per cell
    localparam int GATE_W    = N_CELLS * CELL_SW;
    localparam int LVL_MAX   = CELL_MAX * CELL_SPAN + CELL_MAX;
    localparam int LVL_W     = $clog2(LVL_MAX + 1) + 1;

    typedef logic signed [2:0] cell_code_t;
    typedef logic [CELL_SW-1:0] sw_mask_t;

    // Conducting switch set for one cell code; bit k-1 is switch Sk.
    function automatic sw_mask_t pattern_of(cell_code_t code);
        sw_mask_t m;
        case (int'(code))
            1:       m = 6'b100001;   // S1,S6
            -1:      m = 6'b010100;   // S3,S5
            2:       m = 6'b011000;   // S4,S5
            -2:      m = 6'b100010;   // S2,S6
            3:       m = 6'b001001;   // S1,S4
            -3:      m = 6'b000110;   // S2,S3
            default: m = 6'b001010;   // zero: S2,S4
        endcase
        return m;
    endfunction
endpackage

// File: rtl/ml_enc_split.sv
// Clamps the requested level and splits it into a coarse and a fine share
// using balanced rounding, so both shares stay inside -CELL_MAX..CELL_MAX.
// Assumes a two's-complement request of LVL_W bits. Purely combinational.
module ml_enc_split
    import ml_enc_pkg::*;
(
    input  logic signed [LVL_W-1:0] lvl_in,
    output cell_code_t              coarse,
    output cell_code_t              fine
);
    // Clamp, then decompose: coarse = floor((L + CELL_MAX) / CELL_SPAN).
    always_comb begin
        int lc;
        int q;
        lc = int'(lvl_in);
        if (lc > LVL_MAX)  lc = LVL_MAX;
        if (lc < -LVL_MAX) lc = -LVL_MAX;
        q = (lc + LVL_MAX) / CELL_SPAN - CELL_MAX;
        coarse = cell_code_t'(q);
        fine   = cell_code_t'(lc - q * CELL_SPAN);
    end
endmodule

// File: rtl/ml_enc_cell_map.sv
// Maps one cell share to its conducting switch mask, mirroring the code when
// the primary winding is negative so the cell's output sign is preserved.
module ml_enc_cell_map
    import ml_enc_pkg::*;
(
    input  cell_code_t share,
    input  logic       pri_pos,
    output sw_mask_t   on_mask
);
    cell_code_t eff;

    // Polarity correction followed by table lookup.
    always_comb begin
        eff     = pri_pos ? share : cell_code_t'(-share);
        on_mask = pattern_of(eff);
    end
endmodule

// File: rtl/ml_enc_seq.sv
// Applies a wanted switch mask to the gate outputs. Any change of mask goes
// through DWELL_CYC cycles with only the polarity-matching device gated, and
// changes seen during that dwell wait for it to end. Registered outputs.
module ml_enc_seq
    import ml_enc_pkg::*;
#(
    parameter int DWELL_CYC = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GATE_W-1:0] want,
    input  logic              pri_pos,
    output logic [GATE_W-1:0] gate_a,
    output logic [GATE_W-1:0] gate_b
);
    localparam int CNT_W = $clog2(DWELL_CYC + 1);

    logic [GATE_W-1:0] cur_q;
    logic              armed_q;
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;

    // Dwell sequencer: start on mask change, count down, then gate both devices.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q   <= '0;
            armed_q <= 1'b0;
            busy_q  <= 1'b0;
            cnt_q   <= '0;
            gate_a  <= '0;
            gate_b  <= '0;
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
                gate_a <= cur_q;
                gate_b <= cur_q;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (!armed_q || want != cur_q) begin
            cur_q   <= want;
            armed_q <= 1'b1;
            busy_q  <= 1'b1;
            cnt_q   <= CNT_W'(DWELL_CYC - 1);
            gate_a  <= pri_pos ? want : '0;
            gate_b  <= pri_pos ? '0 : want;
        end
    end
endmodule

// File: rtl/ml_gate_encoder.sv
// Top of the two-cell multilevel gate encoder: level split, per-cell pattern
// mapping with polarity mirroring, and the dwell sequencer on the outputs.
// Assumes requests are timed by upstream control to the primary zero interval.
module ml_gate_encoder
    import ml_enc_pkg::*;
#(
    parameter int DWELL_CYC = 8
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [LVL_W-1:0] lvl_target,
    input  logic                    pri_pos,
    output logic [GATE_W-1:0]       gate_a,
    output logic [GATE_W-1:0]       gate_b
);
    cell_code_t        share [N_CELLS];
    logic [GATE_W-1:0] want;

    ml_enc_split u_split (
        .lvl_in (lvl_target),
        .coarse (share[1]),
        .fine   (share[0])
    );

    for (genvar gi = 0; gi < N_CELLS; gi++) begin : g_cell
        ml_enc_cell_map u_map (
            .share   (share[gi]),
            .pri_pos (pri_pos),
            .on_mask (want[gi*CELL_SW +: CELL_SW])
        );
    end

    ml_enc_seq #(.DWELL_CYC(DWELL_CYC)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .want    (want),
        .pri_pos (pri_pos),
        .gate_a  (gate_a),
        .gate_b  (gate_b)
    );
endmodule

// File: rtl/ml_gate_encoder_chk.sv
// Assertion checker for the gate encoder, bound to every instance.
module ml_gate_encoder_chk
    import ml_enc_pkg::*;
#(
    parameter int DWELL_CYC = 8
)(
    input logic              clk,
    input logic              rst_n,
    input logic [GATE_W-1:0] gate_a,
    input logic [GATE_W-1:0] gate_b
);
    localparam int RUN_W = $clog2(DWELL_CYC + 2) + 1;

    logic [GATE_W-1:0] on_any;
    logic              inter;
    logic [RUN_W-1:0]  run_q;

    assign on_any = gate_a | gate_b;
    assign inter  = (gate_a != gate_b);

    function automatic logic rule_ok(logic [5:0] m);
        return (m[1] == ~(m[0] | m[4])) && (m[3] == ~(m[2] | m[5])) &&
               !(m[4] && (m[0] || m[1])) && !(m[5] && (m[2] || m[3]));
    endfunction

    // Length of the current run of intermediate-state cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)     run_q <= '0;
        else if (inter) run_q <= run_q + 1'b1;
        else            run_q <= '0;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (gate_a == '0 && gate_b == '0));

    a_r10_switch_rules: assert property (@(posedge clk) disable iff (!rst_n)
        (|on_any) |-> (rule_ok(on_any[5:0]) && rule_ok(on_any[11:6])));

    a_r5_one_side_or_both: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_a == gate_b) || (gate_a == '0) || (gate_b == '0));

    a_r6_dwell_bound: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RUN_W'(DWELL_CYC));

    a_r6_dwell_exact: assert property (@(posedge clk) disable iff (!rst_n)
        (!inter && $past(inter) && $past(rst_n)) |-> (run_q == RUN_W'(DWELL_CYC)));
endmodule

bind ml_gate_encoder ml_gate_encoder_chk #(.DWELL_CYC(DWELL_CYC)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .gate_a (gate_a),
    .gate_b (gate_b)
);

// File: tb/ml_gate_encoder_test.sv
// Directed bench for the gate encoder: one task per scenario.
module ml_gate_encoder_test;
    localparam int DW = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic signed [5:0] lvl_target = '0;
    logic              pri_pos = 1'b1;
    logic [11:0]       gate_a;
    logic [11:0]       gate_b;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    ml_gate_encoder #(.DWELL_CYC(DW)) uut (
        .clk(clk), .rst_n(rst_n), .lvl_target(lvl_target),
        .pri_pos(pri_pos), .gate_a(gate_a), .gate_b(gate_b)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Cell pattern from R2, bit k-1 = Sk.
    function automatic logic [5:0] pat(int c);
        case (c)
            1: return 6'b100001;
            -1: return 6'b010100;
            2: return 6'b011000;
            -2: return 6'b100010;
            3: return 6'b001001;
            -3: return 6'b000110;
            default: return 6'b001010;
        endcase
    endfunction

    // Expected conducting mask from R3, R4, R9.
    function automatic logic [11:0] exp_mask(int lvl, bit pos);
        int l = lvl;
        int c = 0;
        int f = 0;
        if (l > 24) l = 24;
        if (l < -24) l = -24;
        for (int a = -3; a <= 3; a++) begin
            if (l - 7 * a >= -3 && l - 7 * a <= 3) begin
                c = a;
                f = l - 7 * a;
            end
        end
        if (!pos) begin
            c = -c;
            f = -f;
        end
        return {pat(c), pat(f)};
    endfunction

    task automatic check(string req, logic [11:0] ea, logic [11:0] eb);
        n_chk++;
        if (gate_a !== ea || gate_b !== eb) begin
            n_fail++;
            $display("FAIL %s: gate_a=%h gate_b=%h expected gate_a=%h gate_b=%h",
                     req, gate_a, gate_b, ea, eb);
        end
    endtask

    task automatic check_inter(string req, logic [11:0] m, bit pos);
        check(req, pos ? m : 12'h0, pos ? 12'h0 : m);
    endtask

    // Drive a request on an idle block and check the dwell and steady state.
    task automatic set_and_verify(int lvl, bit pos, string req);
        logic [11:0] m;
        m = exp_mask(lvl, pos);
        @(negedge clk);
        lvl_target = 6'(lvl);
        pri_pos    = pos;
        @(negedge clk);
        check_inter({req, " R6 dwell start"}, m, pos);
        repeat (DW - 1) @(negedge clk);
        check_inter({req, " R6 dwell end"}, m, pos);
        @(negedge clk);
        check({req, " R5 steady"}, m, m);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 reset", 12'h0, 12'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_inter("R6 first dwell after reset", exp_mask(0, 1), 1'b1);
        repeat (DW) @(negedge clk);
        check("R2 zero pattern S2,S4", exp_mask(0, 1), exp_mask(0, 1));
    endtask

    task automatic t_sweep();
        for (int p = 1; p >= 0; p--) begin
            for (int l = -24; l <= 24; l++) set_and_verify(l, p[0], "R2 R3 R4 sweep");
            set_and_verify(0, 1'b1, "R3 separator");
        end
    endtask

    task automatic t_pol_flip();
        set_and_verify(10, 1'b1, "R4 level 10 positive");
        set_and_verify(10, 1'b0, "R4 level 10 mirrored");
        n_chk++;
        if (exp_mask(10, 0) !== {pat(-1), pat(-3)}) begin
            n_fail++;
            $display("FAIL R4: model mask %h expected %h", exp_mask(10, 0), {pat(-1), pat(-3)});
        end
    endtask

    task automatic t_same_mask();
        logic [11:0] m;
        set_and_verify(0, 1'b0, "R8 prep");
        m = exp_mask(0, 0);
        @(negedge clk);
        pri_pos = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R8 no dwell on unchanged mask", m, m);
        end
    endtask

    task automatic t_hold();
        logic [11:0] mx;
        logic [11:0] my;
        mx = exp_mask(5, 1);
        my = exp_mask(-17, 1);
        @(negedge clk);
        lvl_target = 6'sd5;
        pri_pos    = 1'b1;
        repeat (2) @(negedge clk);
        lvl_target = -6'sd17;
        repeat (DW - 2) @(negedge clk);
        check_inter("R7 earlier dwell kept", mx, 1'b1);
        @(negedge clk);
        check("R7 earlier steady first", mx, mx);
        @(negedge clk);
        check_inter("R7 held request starts", my, 1'b1);
        repeat (DW) @(negedge clk);
        check("R7 held request steady", my, my);
    endtask

    task automatic t_clamp();
        set_and_verify(31, 1'b1, "R9 above range");
        n_chk++;
        if (gate_a !== exp_mask(24, 1)) begin
            n_fail++;
            $display("FAIL R9: gate_a=%h expected %h", gate_a, exp_mask(24, 1));
        end
        set_and_verify(-32, 1'b1, "R9 below range");
        n_chk++;
        if (gate_a !== exp_mask(-24, 1)) begin
            n_fail++;
            $display("FAIL R9: gate_a=%h expected %h", gate_a, exp_mask(-24, 1));
        end
    endtask

    task automatic t_mid_reset();
        set_and_verify(-7, 1'b0, "R10 negative polarity");
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-run", 12'h0, 12'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_inter("R6 dwell after mid-run reset", exp_mask(-7, 0), 1'b0);
    endtask

    initial begin
        t_reset();
        t_sweep();
        t_pol_flip();
        t_same_mask();
        t_hold();
        t_clamp();
        t_mid_reset();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule